// File: doc/BRIEF.md
# Convolutional Interleaver with Per-Branch Delays

This block spreads a symbol stream over a set of parallel delay lines so that symbols that were neighbours on input leave far apart. A commutator deals each accepted symbol to the next branch in turn. Each branch is a shift line whose depth is picked on its own from a per-branch configuration word. The symbol returned in the same slot is the oldest one held by that branch. A branch of depth zero hands its symbol straight back. At reset every cell of a branch is filled with that branch's own preset value. So the first symbols out of a deep branch are those presets and not data.

A build-time mode turns the same structure into the matching deinterleaver. In that mode each branch takes the complement of its configured depth against the maximum depth. A stream that passes through an interleaver and then a deinterleaver with the same depth list therefore reaches its output in order. Every symbol is delayed by the same number of slots, the branch count times the maximum depth. Depth and preset configuration are expected to stay fixed between resets. A depth above the build maximum is treated as the maximum.

Both stream edges use valid/ready. An input symbol is taken on a clock where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the single output register is empty or is being drained in the same cycle. The result of an accepted symbol is presented one clock later. It stays valid and stable until `out_ready` is seen high. With `out_ready` held high the block takes one symbol per clock with no gaps.

Top module: `civ_interleaver`

## Requirements
- R1: After reset the commutator is on branch 0. It moves to the next branch on every accepted input symbol and wraps from branch NUM_BR-1 to branch 0. Branch b of the packed configuration ports occupies bits [b*CFG_W +: CFG_W] of `cfg_delay` and [b*SYM_W +: SYM_W] of `cfg_init`.
- R2: In the interleaving mode, branch b has an effective depth d equal to its configured value. If d is above zero, the symbol accepted on its k-th visit is returned on its (k+d)-th visit.
- R3: A branch whose effective depth is 0 returns the symbol accepted in that slot.
- R4: Reset fills every cell of branch b with `cfg_init` field b. Those presets are returned in order before any data leaves that branch.
- R5: A configured depth above MAX_DLY acts as MAX_DLY.
- R6: With DEINT=1, branch b uses depth MAX_DLY minus its clamped configured depth. An interleaver followed by a deinterleaver with the same depth list returns the input sequence after NUM_BR*MAX_DLY preset symbols.
- R7: `out_valid` is high in the clock after each accepted symbol. With `out_ready` held high, the block accepts a symbol every clock. `out_valid` is low after reset.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` holds its value. Otherwise `in_ready` is high.
- R9: With four branches of depths 0, 1, 2, 3, zero presets and inputs x0, x1, …, the output is x0, 0, 0, 0, x4, x1, 0, 0, x8, x5, x2, 0, x12, x9, …

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; loads presets |
| cfg_delay | input | NUM_BR*CFG_W | Configured depth of each branch |
| cfg_init | input | NUM_BR*SYM_W | Preset value of each branch |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Block can take an input symbol |
| in_data | input | SYM_W | Input symbol |
| out_valid | output | 1 | Output symbol present |
| out_ready | input | 1 | Downstream takes the output symbol |
| out_data | output | SYM_W | Output symbol |

## Verification
The bench builds two instances with eight-bit symbols and four branches. The first is an interleaver with MAX_DLY=5 and a four-bit depth field. That leaves room for a configured depth of 9, which reaches the clamp, next to depth-zero and mid-range branches. The second is a deinterleaver with MAX_DLY=3, chained behind the first. Its back-pressure reaches the interleaver. With depths 0 to 3 the pair reproduces the worked 12-symbol-latency example end to end. A second run uses nonzero presets and irregular valid and ready patterns. In that run the presets, the clamp and the stall rules are visible at the ports.

// File: rtl/civ_pkg.sv
package civ_pkg;

  // Effective depth of one branch: clamp to the build maximum, then
  // mirror against it when the block is built as a deinterleaver.
  function automatic int civ_eff_depth(input int cfg, input int max_dly, input bit deint);
    int c;
    c = (cfg > max_dly) ? max_dly : cfg;
    return deint ? (max_dly - c) : c;
  endfunction

  // Next commutator position with wrap.
  function automatic int civ_next_branch(input int cur, input int nbr);
    return (cur >= nbr - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/civ_delay_map.sv
module civ_delay_map
  import civ_pkg::*;
#(
  parameter int NUM_BR  = 4,
  parameter int CFG_W   = 4,
  parameter int MAX_DLY = 5,
  parameter int DLY_W   = 3,
  parameter bit DEINT   = 1'b0
) (
  input  logic [NUM_BR*CFG_W-1:0] cfg_delay,
  output logic [NUM_BR*DLY_W-1:0] eff_delay
);

  for (genvar b = 0; b < NUM_BR; b++) begin : g_map
    int eff_int;
    always_comb begin
      eff_int = civ_eff_depth(int'(cfg_delay[b*CFG_W +: CFG_W]), MAX_DLY, DEINT);
      eff_delay[b*DLY_W +: DLY_W] = DLY_W'(eff_int);
    end
  end

endmodule

// File: rtl/civ_commutator.sv
module civ_commutator
  import civ_pkg::*;
#(
  parameter int NUM_BR = 4,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [SEL_W-1:0] sel
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= '0;
    end else if (adv) begin
      sel <= SEL_W'(civ_next_branch(int'(sel), NUM_BR));
    end
  end

  AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (int'(sel) == ((int'($past(sel)) == NUM_BR - 1) ? 0 : int'($past(sel)) + 1))); // R1

  AST_RR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(sel)); // R1

endmodule

// File: rtl/civ_branch.sv
module civ_branch #(
  parameter int SYM_W   = 8,
  parameter int MAX_DLY = 5,
  parameter int DLY_W   = 3,
  parameter int PTR_W   = 3,
  parameter int DEPTH   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] init_val,
  input  logic [DLY_W-1:0] dly,
  input  logic             wr_en,
  input  logic [SYM_W-1:0] wr_data,
  output logic [SYM_W-1:0] rd_data
);

  logic [SYM_W-1:0] cells [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic             bypass;
  logic             wrap;

  assign bypass = (dly == '0);
  assign wrap   = (int'(ptr) >= int'(dly) - 1);

  // Oldest entry is read in the same slot the new symbol overwrites it.
  assign rd_data = bypass ? wr_data : cells[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_en && !bypass) begin
      ptr <= wrap ? '0 : ptr + PTR_W'(1);
    end
  end

  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cells[c] <= init_val;
      end else if (wr_en && !bypass && (int'(ptr) == c)) begin
        cells[c] <= wr_data;
      end
    end
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> (int'(ptr) < int'(dly))); // R2

  AST_IDLE_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(ptr)); // R2

endmodule

// File: rtl/civ_out_stage.sv
module civ_out_stage #(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] sel_data,
  output logic             accept,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= sel_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ACCEPT_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8

endmodule

// File: rtl/civ_interleaver.sv
module civ_interleaver #(
  parameter int SYM_W   = 8,
  parameter int NUM_BR  = 4,
  parameter int MAX_DLY = 5,
  parameter int CFG_W   = 4,
  parameter bit DEINT   = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_BR*CFG_W-1:0] cfg_delay,
  input  logic [NUM_BR*SYM_W-1:0] cfg_init,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SYM_W-1:0]        in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [SYM_W-1:0]        out_data
);

  localparam int SEL_W = (NUM_BR > 1) ? $clog2(NUM_BR) : 1;
  localparam int DLY_W = $clog2(MAX_DLY + 1);
  localparam int PTR_W = (MAX_DLY > 1) ? $clog2(MAX_DLY) : 1;
  localparam int DEPTH = (MAX_DLY > 0) ? MAX_DLY : 1;

  logic [NUM_BR*DLY_W-1:0] eff_delay;
  logic [SEL_W-1:0]        sel;
  logic                    accept;
  logic [SYM_W-1:0]        br_rd [NUM_BR];
  logic [SYM_W-1:0]        sel_data;

  civ_delay_map #(
    .NUM_BR (NUM_BR),
    .CFG_W  (CFG_W),
    .MAX_DLY(MAX_DLY),
    .DLY_W  (DLY_W),
    .DEINT  (DEINT)
  ) u_map (
    .cfg_delay(cfg_delay),
    .eff_delay(eff_delay)
  );

  civ_commutator #(
    .NUM_BR(NUM_BR),
    .SEL_W (SEL_W)
  ) u_comm (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (accept),
    .sel  (sel)
  );

  for (genvar b = 0; b < NUM_BR; b++) begin : g_br
    logic wr_en_b;
    assign wr_en_b = accept && (int'(sel) == b);
    civ_branch #(
      .SYM_W  (SYM_W),
      .MAX_DLY(MAX_DLY),
      .DLY_W  (DLY_W),
      .PTR_W  (PTR_W),
      .DEPTH  (DEPTH)
    ) u_branch (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_val(cfg_init[b*SYM_W +: SYM_W]),
      .dly     (eff_delay[b*DLY_W +: DLY_W]),
      .wr_en   (wr_en_b),
      .wr_data (in_data),
      .rd_data (br_rd[b])
    );
  end

  always_comb begin
    sel_data = br_rd[0];
    for (int b = 1; b < NUM_BR; b++) begin
      if (int'(sel) == b) sel_data = br_rd[b];
    end
  end

  civ_out_stage #(
    .SYM_W(SYM_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .sel_data (sel_data),
    .accept   (accept),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  AST_IDLE_OUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && out_ready) |=> !out_valid); // R7

endmodule

// File: tb/civ_interleaver_tb.sv
module civ_interleaver_tb;

  localparam int SW = 8;
  localparam int NB = 4;
  localparam int CW = 4;
  localparam int MA = 5;
  localparam int MB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB*CW-1:0] cfg_a = '0;
  logic [NB*CW-1:0] cfg_b = '0;
  logic [NB*SW-1:0] init_a = '0;
  logic [NB*SW-1:0] init_b = '0;
  logic in_valid = 1'b0;
  logic [SW-1:0] in_data = '0;
  logic in_ready;
  logic a_valid, b_in_ready, b_valid;
  logic [SW-1:0] a_data, b_data;
  logic b_ready = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  civ_interleaver #(.SYM_W(SW), .NUM_BR(NB), .MAX_DLY(MA), .CFG_W(CW), .DEINT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_delay(cfg_a), .cfg_init(init_a),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(a_valid), .out_ready(b_in_ready), .out_data(a_data)
  );

  civ_interleaver #(.SYM_W(SW), .NUM_BR(NB), .MAX_DLY(MB), .CFG_W(CW), .DEINT(1'b1)) u_deint (
    .clk(clk), .rst_n(rst_n), .cfg_delay(cfg_b), .cfg_init(init_b),
    .in_valid(a_valid), .in_ready(b_in_ready), .in_data(a_data),
    .out_valid(b_valid), .out_ready(b_ready), .out_data(b_data)
  );

  // Behavioural model state
  logic [SW-1:0] qa [NB][$];
  logic [SW-1:0] qb [NB][$];
  int pa, pb;
  bit ma_v, mb_v;
  logic [SW-1:0] ma_d, mb_d;
  logic [SW-1:0] in_log[$];
  logic [SW-1:0] a_log[$];
  logic [SW-1:0] b_log[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      int da, db, c;
      c  = int'(cfg_a[b*CW +: CW]);
      da = (c > MA) ? MA : c;
      c  = int'(cfg_b[b*CW +: CW]);
      db = MB - ((c > MB) ? MB : c);
      qa[b].delete();
      qb[b].delete();
      for (int k = 0; k < da; k++) qa[b].push_back(init_a[b*SW +: SW]);
      for (int k = 0; k < db; k++) qb[b].push_back(init_b[b*SW +: SW]);
    end
    pa = 0; pb = 0; ma_v = 0; mb_v = 0; ma_d = '0; mb_d = '0;
    in_log.delete(); a_log.delete(); b_log.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; b_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1;
    chk(a_valid == 1'b0, "R7 reset out_valid", int'(a_valid), 0);
    chk(in_ready == 1'b1, "R8 reset in_ready", int'(in_ready), 1);
  endtask

  // One clock: drive at the falling edge, compare, advance the model.
  task automatic step(input bit iv, input logic [SW-1:0] id, input bit br);
    bit brdy, ardy, acc_a, acc_b;
    logic [SW-1:0] o;
    in_valid = iv; in_data = id; b_ready = br;
    #1;
    brdy = !mb_v || br;
    ardy = !ma_v || brdy;
    chk(in_ready == ardy, "R8 in_ready", int'(in_ready), int'(ardy));
    chk(a_valid == ma_v, "R7 out_valid", int'(a_valid), int'(ma_v));
    if (ma_v) chk(a_data == ma_d, "R2 out_data", int'(a_data), int'(ma_d));
    chk(b_valid == mb_v, "R6 deint valid", int'(b_valid), int'(mb_v));
    if (mb_v) chk(b_data == mb_d, "R6 deint data", int'(b_data), int'(mb_d));
    acc_b = ma_v && brdy;
    acc_a = iv && ardy;
    if (mb_v && br) b_log.push_back(b_data);
    if (acc_b) begin
      a_log.push_back(a_data);
      qb[pb].push_back(ma_d);
      o = qb[pb].pop_front();
      pb = (pb + 1) % NB;
      mb_v = 1; mb_d = o;
    end else if (br) mb_v = 0;
    if (acc_a) begin
      in_log.push_back(id);
      qa[pa].push_back(id);
      o = qa[pa].pop_front();
      pa = (pa + 1) % NB;
      ma_v = 1; ma_d = o;
    end else if (brdy) ma_v = 0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // Phase 1: depths 0,1,2,3 on both, zero presets, continuous flow
    cfg_a = {4'd3, 4'd2, 4'd1, 4'd0};
    cfg_b = {4'd3, 4'd2, 4'd1, 4'd0};
    init_a = '0; init_b = '0;
    do_reset();
    for (int k = 0; k < 40; k++) step(1'b1, SW'(8'h10 + k), 1'b1);
    for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1);

    // R9 worked example: slot k comes from input k-4*(k%4), else preset 0
    for (int k = 0; k < 16; k++) begin
      int src;
      src = k - 4 * (k % 4);
      if (src >= 0) chk(a_log[k] == in_log[src], "R9 example", int'(a_log[k]), int'(in_log[src]));
      else          chk(a_log[k] == 8'h00, "R9 example", int'(a_log[k]), 0);
    end
    chk(a_log[4] == in_log[4], "R1 wrap to branch 0", int'(a_log[4]), int'(in_log[4]));
    chk(a_log[8] == in_log[8], "R3 zero depth", int'(a_log[8]), int'(in_log[8]));
    chk(a_log[13] == in_log[9], "R2 depth 1", int'(a_log[13]), int'(in_log[9]));
    for (int k = 0; k < 28; k++) begin
      if (k < 12) chk(b_log[k] == 8'h00, "R6 preset span", int'(b_log[k]), 0);
      else        chk(b_log[k] == in_log[k-12], "R6 order restored", int'(b_log[k]), int'(in_log[k-12]));
    end

    // Phase 2: clamped depth, presets, irregular valid and ready
    cfg_a  = {4'd2, 4'd4, 4'd0, 4'd9};
    init_a = {8'hD4, 8'hC3, 8'hB2, 8'hA1};
    init_b = {8'h5D, 8'h5C, 8'h5B, 8'h5A};
    do_reset();
    for (int k = 0; k < 240; k++)
      step((k % 3) != 2, SW'(k * 7 + 3), (k % 5) != 3);
    for (int k = 0; k < 10; k++) step(1'b0, '0, 1'b1);

    chk(a_log[0] == 8'hA1, "R4 preset first", int'(a_log[0]), 'hA1);
    chk(a_log[4] == 8'hA1, "R4 preset repeat", int'(a_log[4]), 'hA1);
    chk(a_log[2] == 8'hC3, "R4 preset branch 2", int'(a_log[2]), 'hC3);
    chk(a_log[1] == in_log[1], "R3 zero depth", int'(a_log[1]), int'(in_log[1]));
    chk(a_log[16] == 8'hA1, "R5 clamp presets", int'(a_log[16]), 'hA1);
    chk(a_log[20] == in_log[0], "R5 clamp to max", int'(a_log[20]), int'(in_log[0]));
    chk(a_log[11] == in_log[3], "R2 depth 2", int'(a_log[11]), int'(in_log[3]));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule